// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block is a bus-master DMA engine that moves a buffer of a given byte count between a local data buffer and host memory. The host memory is described by a table of descriptors. Each descriptor names one contiguous host region. The engine fetches one 8-byte descriptor at a time through a read-only memory port. It decodes the region address, the region length and the final-entry flag. It then issues data bursts on a second memory port. Each burst carries the host address, the byte length, the offset into the local buffer and the direction. The memory subsystem performs the actual data copy and accepts each burst with a valid/ready handshake.

Software loads the table base with a restart pulse while the engine is idle. It then requests transfers with a start pulse, a direction and a byte count. The descriptor pointer is kept across transfers, so a second start without a restart carries on with the next unread descriptor. Every transfer ends with a one-cycle done pulse. A short-table flag is raised with it when the descriptors ran out before the buffer was fully moved. The table walk is cut off after one 4 KiB page of descriptors, so a table with no final-entry flag cannot run away.

Top module: `prd_dma_engine`

## Requirements
- R1: A descriptor fetch reads 8 bytes at the current pointer. The response word carries the region address in bits 31:0 and the size/flag word in bits 63:32, both little-endian. The first data burst of a region goes to that region address.
- R2: The region length is the size word ANDed with 0xFFFE. Bit 0 and bits 16 to 30 of the size word never change the length.
- R3: A decoded region length of zero stands for 65536 bytes.
- R4: Bit 31 of the size word (response bit 63) marks the final descriptor, and no descriptor is fetched after it within the transfer.
- R5: Each descriptor fetch advances the pointer by 8. A restart pulse while idle reloads the pointer and the page-limit base from the table base input. A start pulse leaves the pointer where the previous transfer left it.
- R6: A descriptor is fetched only when the remaining length of the current region is zero and bytes are still to be moved.
- R7: No descriptor is fetched once the pointer has advanced 4096 bytes or more past the base. The transfer then ends as short if bytes remain.
- R8: Each burst moves the smaller of the bytes still needed and the bytes left in the region. The burst carries the transfer direction. The region address and the buffer index both advance by the burst length.
- R9: A transfer ends with a single-cycle done pulse. Short-table is raised with done exactly when the table ended before the whole byte count was moved.
- R10: A start pulse discards any region left over from the previous transfer: its remaining length, its address and its final flag.
- R11: At most one memory request is pending at a time. A request holds its valid, address and length unchanged until it is accepted.
- R12: After reset the engine is idle with no request and no done pulse. A zero-byte transfer completes with done and without short-table, and fetches no descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| table_base | input | ADDR_W | Descriptor table base address, loaded on restart |
| restart | input | 1 | Reload pointer and page base from table_base (idle only) |
| start | input | 1 | Begin a transfer (idle only) |
| start_write | input | 1 | Direction: 1 = buffer to host memory, 0 = host memory to buffer |
| start_bytes | input | BUF_W | Byte count of the transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| short_table | output | 1 | With done: table ended before the byte count was met |
| desc_req_valid | output | 1 | Descriptor fetch request |
| desc_req_ready | input | 1 | Descriptor fetch accepted |
| desc_req_addr | output | ADDR_W | Byte address of the 8-byte descriptor |
| desc_rsp_valid | input | 1 | Descriptor data returned |
| desc_rsp_data | input | 64 | Descriptor word: size/flag in 63:32, address in 31:0 |
| data_req_valid | output | 1 | Data burst request |
| data_req_ready | input | 1 | Data burst accepted |
| data_req_write | output | 1 | Burst direction, as start_write |
| data_req_addr | output | ADDR_W | Host byte address of the burst |
| data_req_len | output | 17 | Burst length in bytes (1 to 65536) |
| data_req_index | output | BUF_W | Local buffer byte offset of the burst |

## Verification
The hardest condition to reach from the ports is the page fail-safe. It needs a table of 512 descriptors, none flagged final, and a byte count larger than their total, so that the walk stops on pointer distance alone. The bench fills the whole page with 2-byte regions and asks for 2000 bytes. It expects exactly 512 fetches and a short end. A second hard case is a region that is only partly used when a transfer finishes. A following start must skip the remainder of that region and fetch the next descriptor. The bench reaches this by ending one transfer inside a 1 KiB region and starting again without a restart. Random ready stalls on both ports run throughout the bench, so every request is held across several cycles.

// File: rtl/prd_pkg.sv
`timescale 1ns/1ps
package prd_pkg;
  // Descriptor word and length field geometry (fixed by the table format)
  localparam int DESC_W       = 64;
  localparam int CNT_FIELD_W  = 16;
  localparam int REGION_LEN_W = CNT_FIELD_W + 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_STEP,
    S_DREQ,
    S_DWAIT,
    S_BURST
  } prd_state_e;
endpackage

// File: rtl/prd_desc_decode.sv
`timescale 1ns/1ps
module prd_desc_decode
  import prd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [DESC_W-1:0]       word,
  output logic [ADDR_W-1:0]       region_addr,
  output logic [REGION_LEN_W-1:0] region_len,
  output logic                    region_last
);
  localparam int HALF = DESC_W / 2;

  logic [HALF-1:0]        size_word;
  logic [CNT_FIELD_W-1:0] even_cnt;

  assign size_word   = word[DESC_W-1:HALF];
  assign region_addr = ADDR_W'(word[HALF-1:0]);
  assign even_cnt    = {size_word[CNT_FIELD_W-1:1], 1'b0};
  assign region_last = size_word[HALF-1];

  always_comb begin
    if (even_cnt == '0) region_len = REGION_LEN_W'(1) << CNT_FIELD_W;
    else                region_len = {1'b0, even_cnt};
  end
endmodule

// File: rtl/prd_burst_sizer.sv
`timescale 1ns/1ps
module prd_burst_sizer
  import prd_pkg::*;
#(
  parameter int BUF_W = 20
) (
  input  logic [BUF_W-1:0]        need,
  input  logic [REGION_LEN_W-1:0] region,
  output logic [REGION_LEN_W-1:0] burst
);
  localparam int CW = (BUF_W > REGION_LEN_W) ? BUF_W : REGION_LEN_W;

  logic [CW-1:0] need_x;
  logic [CW-1:0] region_x;

  assign need_x   = CW'(need);
  assign region_x = CW'(region);
  assign burst    = (need_x < region_x) ? need_x[REGION_LEN_W-1:0] : region;
endmodule

// File: rtl/prd_dma_engine.sv
`timescale 1ns/1ps
module prd_dma_engine
  import prd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BUF_W      = 20,
  parameter int PAGE_BYTES = 4096,
  parameter int DESC_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       table_base,
  input  logic                    restart,
  input  logic                    start,
  input  logic                    start_write,
  input  logic [BUF_W-1:0]        start_bytes,
  output logic                    busy,
  output logic                    done,
  output logic                    short_table,
  output logic                    desc_req_valid,
  input  logic                    desc_req_ready,
  output logic [ADDR_W-1:0]       desc_req_addr,
  input  logic                    desc_rsp_valid,
  input  logic [DESC_W-1:0]       desc_rsp_data,
  output logic                    data_req_valid,
  input  logic                    data_req_ready,
  output logic                    data_req_write,
  output logic [ADDR_W-1:0]       data_req_addr,
  output logic [REGION_LEN_W-1:0] data_req_len,
  output logic [BUF_W-1:0]        data_req_index
);
  localparam logic [ADDR_W-1:0] PAGE_LIM = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PTR_STEP = ADDR_W'(DESC_BYTES);

  prd_state_e state;

  logic [ADDR_W-1:0]       ptr_q, base_q, cur_addr_q;
  logic [REGION_LEN_W-1:0] cur_len_q, burst_q;
  logic                    cur_last_q, dir_q, done_q, short_q;
  logic [BUF_W-1:0]        rem_q, idx_q;

  logic [ADDR_W-1:0]       dec_addr;
  logic [REGION_LEN_W-1:0] dec_len, size_now;
  logic                    dec_last, page_hit;

  prd_desc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .word        (desc_rsp_data),
    .region_addr (dec_addr),
    .region_len  (dec_len),
    .region_last (dec_last)
  );

  prd_burst_sizer #(.BUF_W(BUF_W)) u_sizer (
    .need   (rem_q),
    .region (cur_len_q),
    .burst  (size_now)
  );

  // Distance walked from the table base (fail-safe limit)
  assign page_hit = (ptr_q - base_q) >= PAGE_LIM;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ptr_q      <= '0;
      base_q     <= '0;
      cur_addr_q <= '0;
      cur_len_q  <= '0;
      cur_last_q <= 1'b0;
      burst_q    <= '0;
      dir_q      <= 1'b0;
      rem_q      <= '0;
      idx_q      <= '0;
      done_q     <= 1'b0;
      short_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      short_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (restart) begin
            ptr_q  <= table_base;
            base_q <= table_base;
          end
          if (start) begin
            rem_q      <= start_bytes;
            idx_q      <= '0;
            dir_q      <= start_write;
            cur_addr_q <= '0;
            cur_len_q  <= '0;
            cur_last_q <= 1'b0;
            state      <= S_STEP;
          end
        end
        S_STEP: begin
          if (rem_q == '0) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else if (cur_len_q == '0) begin
            if (cur_last_q || page_hit) begin
              done_q  <= 1'b1;
              short_q <= 1'b1;
              state   <= S_IDLE;
            end else begin
              state <= S_DREQ;
            end
          end else begin
            burst_q <= size_now;
            state   <= S_BURST;
          end
        end
        S_DREQ: begin
          if (desc_req_ready) begin
            ptr_q <= ptr_q + PTR_STEP;
            state <= S_DWAIT;
          end
        end
        S_DWAIT: begin
          if (desc_rsp_valid) begin
            cur_addr_q <= dec_addr;
            cur_len_q  <= dec_len;
            cur_last_q <= dec_last;
            state      <= S_STEP;
          end
        end
        S_BURST: begin
          if (data_req_ready) begin
            cur_addr_q <= cur_addr_q + ADDR_W'(burst_q);
            cur_len_q  <= cur_len_q - burst_q;
            rem_q      <= rem_q - BUF_W'(burst_q);
            idx_q      <= idx_q + BUF_W'(burst_q);
            state      <= S_STEP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy           = (state != S_IDLE);
  assign done           = done_q;
  assign short_table    = short_q;
  assign desc_req_valid = (state == S_DREQ);
  assign desc_req_addr  = ptr_q;
  assign data_req_valid = (state == S_BURST);
  assign data_req_write = dir_q;
  assign data_req_addr  = cur_addr_q;
  assign data_req_len   = burst_q;
  assign data_req_index = idx_q;
endmodule

// File: rtl/prd_dma_checks.sv
`timescale 1ns/1ps
module prd_dma_checks
  import prd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    busy,
  input logic                    done,
  input logic                    short_table,
  input logic                    desc_req_valid,
  input logic                    desc_req_ready,
  input logic [ADDR_W-1:0]       desc_req_addr,
  input logic                    data_req_valid,
  input logic                    data_req_ready,
  input logic [ADDR_W-1:0]       data_req_addr,
  input logic [REGION_LEN_W-1:0] data_req_len
);
  localparam logic [REGION_LEN_W-1:0] MAX_LEN = REGION_LEN_W'(1) << CNT_FIELD_W;

  p_single_pending_r11: assert property (@(posedge clk) disable iff (rst)
    !(desc_req_valid && data_req_valid));

  p_desc_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (desc_req_valid && !desc_req_ready) |=> (desc_req_valid && $stable(desc_req_addr)));

  p_data_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (data_req_valid && !data_req_ready) |=>
      (data_req_valid && $stable(data_req_addr) && $stable(data_req_len)));

  p_burst_bounds_r8: assert property (@(posedge clk) disable iff (rst)
    data_req_valid |-> (data_req_len != '0 && data_req_len <= MAX_LEN));

  p_short_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    short_table |-> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!desc_req_valid && !data_req_valid));
endmodule

bind prd_dma_engine prd_dma_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk            (clk),
  .rst            (rst),
  .busy           (busy),
  .done           (done),
  .short_table    (short_table),
  .desc_req_valid (desc_req_valid),
  .desc_req_ready (desc_req_ready),
  .desc_req_addr  (desc_req_addr),
  .data_req_valid (data_req_valid),
  .data_req_ready (data_req_ready),
  .data_req_addr  (data_req_addr),
  .data_req_len   (data_req_len)
);

// File: tb/tb_prd_dma_engine.sv
`timescale 1ns/1ps
module tb_prd_dma_engine;
  localparam int ADDR_W = 32;
  localparam int BUF_W  = 20;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic [ADDR_W-1:0] table_base = '0;
  logic              restart = 1'b0, start = 1'b0, start_write = 1'b0;
  logic [BUF_W-1:0]  start_bytes = '0;
  logic              busy, done, short_table;
  logic              desc_req_valid, desc_req_ready = 1'b0;
  logic [ADDR_W-1:0] desc_req_addr;
  logic              desc_rsp_valid = 1'b0;
  logic [63:0]       desc_rsp_data = '0;
  logic              data_req_valid, data_req_ready = 1'b0, data_req_write;
  logic [ADDR_W-1:0] data_req_addr;
  logic [16:0]       data_req_len;
  logic [BUF_W-1:0]  data_req_index;

  prd_dma_engine #(.ADDR_W(ADDR_W), .BUF_W(BUF_W)) dut (.*);

  typedef struct {
    logic [31:0] addr;
    int          len;
    int          idx;
    logic        wr;
  } burst_t;

  logic [63:0] tbl [0:511];
  burst_t      exp_b[$];
  logic [31:0] exp_d[$];
  int          checks = 0, fails = 0;
  logic [31:0] m_ptr = '0, m_base = '0;
  logic [7:0]  lfsr = 8'hA5;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor and memory responder: samples at negedge, away from the active edge
  initial begin
    bit          pend = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      if (pend) begin
        desc_rsp_valid = 1'b1;
        desc_rsp_data  = tbl[paddr[11:3]];
        pend = 0;
      end else begin
        desc_rsp_valid = 1'b0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      desc_req_ready = lfsr[0] | lfsr[3];
      data_req_ready = lfsr[1] | lfsr[6];
      if (!rst && desc_req_valid && data_req_valid)
        chk(0, "R11", "two requests pending", 1, 0);
      if (!rst && desc_req_valid && desc_req_ready) begin
        pend  = 1;
        paddr = desc_req_addr;
        if (exp_d.size() == 0) chk(0, "R6", "unexpected descriptor fetch", desc_req_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_d.pop_front();
          chk(desc_req_addr == e, "R5", "descriptor fetch address", desc_req_addr, e);
        end
      end
      if (!rst && data_req_valid && data_req_ready) begin
        if (exp_b.size() == 0) chk(0, "R8", "unexpected burst", data_req_addr, 0);
        else begin
          burst_t b;
          b = exp_b.pop_front();
          chk(data_req_addr == b.addr, "R1", "burst address", data_req_addr, b.addr);
          chk(int'(data_req_len) == b.len, "R8", "burst length", data_req_len, b.len);
          chk(int'(data_req_index) == b.idx, "R8", "burst buffer index", data_req_index, b.idx);
          chk(data_req_write == b.wr, "R8", "burst direction", data_req_write, b.wr);
        end
      end
    end
  end

  // Reference walk computed from the requirements
  task automatic model_xfer(input int bytes, input logic wr, output bit exp_short);
    int rem = bytes, len = 0, idx = 0, l;
    bit last = 0;
    logic [31:0] caddr = '0;
    logic [63:0] w;
    exp_short = 0;
    while (1) begin
      if (rem == 0) break;
      if (len == 0) begin
        if (last || (m_ptr - m_base) >= 32'd4096) begin
          exp_short = 1;
          break;
        end
        exp_d.push_back(m_ptr);
        w = tbl[m_ptr[11:3]];
        m_ptr = m_ptr + 32'd8;
        len = int'(w[47:32] & 16'hFFFE);
        if (len == 0) len = 65536;
        caddr = w[31:0];
        last  = w[63];
      end
      l = (rem < len) ? rem : len;
      exp_b.push_back('{caddr, l, idx, wr});
      caddr = caddr + 32'(l);
      len -= l;
      idx += l;
      rem -= l;
    end
  endtask

  task automatic do_restart(input logic [31:0] base);
    @(negedge clk);
    table_base = base;
    restart    = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    m_base  = base;
    m_ptr   = base;
  endtask

  task automatic run(input int bytes, input logic wr, input string req);
    bit exp_short;
    bit seen = 0;
    model_xfer(bytes, wr, exp_short);
    @(negedge clk);
    start_bytes = BUF_W'(bytes);
    start_write = wr;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        break;
      end
    end
    chk(seen, "R9", {req, " done pulse"}, seen, 1);
    chk(short_table == exp_short, "R9", {req, " short flag"}, short_table, exp_short);
    @(negedge clk);
    chk(!done, "R9", {req, " done lasts one cycle"}, done, 0);
    chk(!busy, "R12", {req, " idle after done"}, busy, 0);
    chk(exp_d.size() == 0, "R6", {req, " descriptor fetches left"}, exp_d.size(), 0);
    chk(exp_b.size() == 0, "R8", {req, " bursts left"}, exp_b.size(), 0);
    exp_d.delete();
    exp_b.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(!busy && !done && !short_table, "R12", "reset status", {busy, done, short_table}, 0);
    chk(!desc_req_valid && !data_req_valid, "R12", "reset requests",
        {desc_req_valid, data_req_valid}, 0);

    // R1, R2, R4: single final descriptor with bit 0 set in the count
    do_restart(32'h0001_0000);
    tbl[0] = {32'h8000_0201, 32'h0020_0000};
    run(32'h200, 1'b1, "R2 odd count bit");

    // R6, R8, R2: three regions, last one partly used; bits 16+ set in d1
    do_restart(32'h0001_0000);
    tbl[0] = {32'h0000_0100, 32'h0030_0000};
    tbl[1] = {32'h0005_0081, 32'h0031_0000};
    tbl[2] = {32'h8000_0400, 32'h0032_0000};
    tbl[3] = {32'h8000_0040, 32'h0040_0000};
    run(32'h300, 1'b0, "R8 multi region");

    // R10, R5: start without restart drops the leftover region, fetches at base+0x18
    run(32'h40, 1'b1, "R10 continue table");

    // R3, R4, R9: zero count means 64 KiB, table ends short
    do_restart(32'h0001_0000);
    tbl[0] = {32'h8000_0000, 32'h0050_0000};
    run(70000, 1'b1, "R3 zero count");

    // R8: odd byte count inside an even region
    do_restart(32'h0001_0000);
    tbl[0] = {32'h8000_0004, 32'h0060_0001};
    run(3, 1'b0, "R8 odd buffer");

    // R12: zero-byte transfer
    run(0, 1'b1, "R12 zero bytes");

    // R7: page fail-safe with no final flag anywhere
    do_restart(32'h0002_0000);
    for (int i = 0; i < 512; i++) tbl[i] = {32'h0000_0002, 32'h0070_0000 + 32'(i * 2)};
    run(2000, 1'b1, "R7 page limit");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule